// File: doc/BRIEF.md
# Dual-Register Serial Discrete Input Interface

This block is the digital core of an eight-channel discrete input sensor. It offers a serial slave port with chip select, shift clock, serial data in and serial data out. A select pin picks one of two 8-bit shift registers. The data register captures the eight channel levels in parallel when chip select falls. It then shifts them out, most significant bit first. The configuration register takes serial data in. When chip select rises, it copies its contents into eight latched mode outputs, one per channel, and each output sets that channel's sensing mode.

Both registers pass data from serial in to serial out. Two blocks wired serial-out to serial-in can therefore be read or written in one 16-clock frame. All port pins are sampled by a faster system clock through two-flop synchronizers. Register updates are driven by the edges detected on the synchronized pins, so every update is synchronous. The three-state serial output is modelled as a data bit plus an output-enable bit.

Top module: `dsi_discrete_if`

## Requirements
- R1: After reset, `mode_o` is all zeros (every channel in pull-down mode) and `sdo_oe_o` is 0.
- R2: While `cs_ni` is high, `sdo_oe_o` is 0 and shift clock edges change neither register; a later empty frame on the configuration register therefore latches the unchanged contents.
- R3: With `sel_i` high (1 = data register), the falling edge of `cs_ni` loads `chan_i` into the data register, with a low level giving 0 and a high level giving 1.
- R4: On each rising `sclk_i` edge while `cs_ni` is low, the selected register shifts up one place: `sdi_i` enters bit 0, and bit k moves to bit k+1.
- R5: With `sel_i` low (0 = configuration register), `mode_o` takes the configuration shift register contents on the rising edge of `cs_ni` and does not change at any other time.
- R6: `sdo_o` is bit 7 of the selected register, and `sdo_oe_o` is 1 while `cs_ni` is low.
- R7: A data-register frame leaves `mode_o` unchanged.
- R8: A configuration frame with fewer than 8 clocks still latches the partially shifted contents on the rising edge of `cs_ni`.
- R9: With two blocks chained serial-out to serial-in, one 16-clock read returns the far block's 8 channel bits first and then the near block's 8 channel bits.
- R10: With two blocks chained, one 16-clock configuration write leaves the first 8 bits sent in the far block and the last 8 bits sent in the near block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; it samples all pins and must run several times faster than sclk_i |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Chip select, active low |
| sclk_i | input | 1 | Serial shift clock; data shifts on its rising edge |
| sdi_i | input | 1 | Serial data in |
| sel_i | input | 1 | Register select: 1 = data register, 0 = configuration register |
| chan_i | input | N_CH | Discrete channel levels |
| sdo_o | output | 1 | Serial data out, bit 7 of the selected register |
| sdo_oe_o | output | 1 | Output enable for sdo_o, 1 while selected |
| mode_o | output | N_CH | Latched channel modes: 0 = pull-down, 1 = pull-up |

## Verification
A corrupted data register shows on `sdo_o` at the first bit of the next read frame, before any clock. A bit lost in the shift path shows within one shift clock as a misaligned serial stream. A wrong configuration shift register stays hidden on `mode_o` until the next rising chip select, but the following configuration frame exposes it on `sdo_o` as it shifts out the old contents. Latency from a pin to a register is three system clocks: two synchronizer stages and one update edge. The chained tests show a stale or misordered pass-through as swapped bytes.

// File: rtl/dsi_pkg.sv
package dsi_pkg;
  localparam int unsigned DEF_N_CH = 8;
  typedef enum logic {SEL_CFG = 1'b0, SEL_DATA = 1'b1} reg_sel_e;
endpackage

// File: rtl/dsi_sync.sv
module dsi_sync #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic meta_q, sync_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL[b];
        sync_q <= RST_VAL[b];
      end else begin
        meta_q <= d_i[b];
        sync_q <= meta_q;
      end
    end
    assign q_o[b] = sync_q;
  end
endmodule

// File: rtl/dsi_edge.sv
module dsi_edge #(
  parameter bit RISING  = 1'b1,
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  output logic edge_o
);
  logic prev_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= s_i;
  end
  if (RISING) begin : g_rise
    assign edge_o = s_i & ~prev_q;
  end else begin : g_fall
    assign edge_o = ~s_i & prev_q;
  end
endmodule

// File: rtl/dsi_shreg.sv
module dsi_shreg #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [N-1:0] par_i,
  input  logic         shift_i,
  input  logic         sdi_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q <= '0;
    else if (load_i)  q <= par_i;
    else if (shift_i) q <= {q[N-2:0], sdi_i};
  end
  assign q_o = q;
endmodule

// File: rtl/dsi_latch.sv
module dsi_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/dsi_discrete_if.sv
module dsi_discrete_if
  import dsi_pkg::*;
#(
  parameter int unsigned N_CH = DEF_N_CH
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            cs_ni,
  input  logic            sclk_i,
  input  logic            sdi_i,
  input  logic            sel_i,
  input  logic [N_CH-1:0] chan_i,
  output logic            sdo_o,
  output logic            sdo_oe_o,
  output logic [N_CH-1:0] mode_o
);
  localparam int unsigned MSB = N_CH - 1;

  // pin order in the sync vector: {sdi, sel, sclk, cs}
  logic [3:0] pins_s;
  logic cs_s, sclk_s, sel_s, sdi_s;
  logic [N_CH-1:0] chan_s;
  reg_sel_e sel_e;

  dsi_sync #(.W(4), .RST_VAL(4'b0001)) u_sync_pins (
    .clk_i, .rst_ni, .d_i({sdi_i, sel_i, sclk_i, cs_ni}), .q_o(pins_s)
  );
  dsi_sync #(.W(N_CH), .RST_VAL('0)) u_sync_chan (
    .clk_i, .rst_ni, .d_i(chan_i), .q_o(chan_s)
  );

  assign cs_s   = pins_s[0];
  assign sclk_s = pins_s[1];
  assign sel_s  = pins_s[2];
  assign sdi_s  = pins_s[3];
  assign sel_e  = reg_sel_e'(sel_s);

  logic cs_rise, cs_fall, sclk_rise;
  dsi_edge #(.RISING(1'b1), .RST_VAL(1'b1)) u_cs_rise (
    .clk_i, .rst_ni, .s_i(cs_s), .edge_o(cs_rise)
  );
  dsi_edge #(.RISING(1'b0), .RST_VAL(1'b1)) u_cs_fall (
    .clk_i, .rst_ni, .s_i(cs_s), .edge_o(cs_fall)
  );
  dsi_edge #(.RISING(1'b1), .RST_VAL(1'b0)) u_sclk_rise (
    .clk_i, .rst_ni, .s_i(sclk_s), .edge_o(sclk_rise)
  );

  logic shift_evt, load_evt, latch_evt;
  assign shift_evt = sclk_rise & ~cs_s;
  assign load_evt  = cs_fall & (sel_e == SEL_DATA);
  assign latch_evt = cs_rise & (sel_e == SEL_CFG);

  logic [N_CH-1:0] data_q, cfg_q;
  dsi_shreg #(.N(N_CH)) u_data_reg (
    .clk_i, .rst_ni, .load_i(load_evt), .par_i(chan_s),
    .shift_i(shift_evt & (sel_e == SEL_DATA)), .sdi_i(sdi_s), .q_o(data_q)
  );
  dsi_shreg #(.N(N_CH)) u_cfg_reg (
    .clk_i, .rst_ni, .load_i(1'b0), .par_i('0),
    .shift_i(shift_evt & (sel_e == SEL_CFG)), .sdi_i(sdi_s), .q_o(cfg_q)
  );
  dsi_latch #(.N(N_CH)) u_mode_latch (
    .clk_i, .rst_ni, .en_i(latch_evt), .d_i(cfg_q), .q_o(mode_o)
  );

  assign sdo_o    = (sel_e == SEL_DATA) ? data_q[MSB] : cfg_q[MSB];
  assign sdo_oe_o = ~cs_s;
endmodule

// File: rtl/dsi_discrete_if_chk.sv
module dsi_discrete_if_chk #(
  parameter int unsigned N_CH = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            cs_s,
  input logic            sel_s,
  input logic            sdi_s,
  input logic [N_CH-1:0] chan_s,
  input logic            shift_evt,
  input logic            load_evt,
  input logic            latch_evt,
  input logic [N_CH-1:0] data_q,
  input logic [N_CH-1:0] cfg_q,
  input logic [N_CH-1:0] mode_o
);
  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> ($stable(data_q) && $stable(cfg_q)));

  p_par_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_evt |=> (data_q == $past(chan_s)));

  p_data_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_evt && sel_s) |=> (data_q == {$past(data_q[N_CH-2:0]), $past(sdi_s)}));

  p_cfg_shift_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shift_evt && !sel_s) |=> (cfg_q == {$past(cfg_q[N_CH-2:0]), $past(sdi_s)}));

  p_latch_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    latch_evt |=> (mode_o == $past(cfg_q)));

  p_mode_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !latch_evt |=> $stable(mode_o));
endmodule

bind dsi_discrete_if dsi_discrete_if_chk #(.N_CH(N_CH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_s(cs_s), .sel_s(sel_s), .sdi_s(sdi_s),
  .chan_s(chan_s), .shift_evt(shift_evt), .load_evt(load_evt),
  .latch_evt(latch_evt), .data_q(data_q), .cfg_q(cfg_q), .mode_o(mode_o)
);

// File: tb/dsi_discrete_if_tb.sv
`timescale 1ns/1ps
module dsi_discrete_if_tb;
  localparam int CLK_P = 10;
  localparam int HOLD  = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, sdi = 1'b0, sel = 1'b1;
  logic [7:0] chan_a = '0, chan_b = '0;
  logic sdo_a, oe_a, sdo_b, oe_b;
  logic [7:0] mode_a, mode_b;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  dsi_discrete_if u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sel_i(sel), .chan_i(chan_a), .sdo_o(sdo_a), .sdo_oe_o(oe_a), .mode_o(mode_a)
  );
  dsi_discrete_if u_dut2 (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sclk_i(sclk), .sdi_i(sdo_a),
    .sel_i(sel), .chan_i(chan_b), .sdo_o(sdo_b), .sdo_oe_o(oe_b), .mode_o(mode_b)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame_open(input logic s);
    sel = s;
    wait_cyc(HOLD);
    cs_n = 1'b0;
    wait_cyc(HOLD);
  endtask

  task automatic frame_close();
    cs_n = 1'b1;
    wait_cyc(HOLD);
  endtask

  // tap 0 observes u_dut, tap 1 observes the far end of the chain
  task automatic frame_bits(input int n, input logic [15:0] wr, input bit tap,
                            output logic [15:0] rd);
    rd = '0;
    for (int i = 0; i < n; i++) begin
      sdi = wr[n-1-i];
      wait_cyc(2);
      rd[n-1-i] = tap ? sdo_b : sdo_a;
      sclk = 1'b1;
      wait_cyc(HOLD);
      sclk = 1'b0;
      wait_cyc(HOLD);
    end
  endtask

  task automatic t_reset();
    check("R1 mode_a after reset", mode_a, 8'h00);
    check("R1 mode_b after reset", mode_b, 8'h00);
    check("R1 oe after reset", oe_a, 1'b0);
  endtask

  task automatic t_read(input logic [7:0] pat);
    logic [15:0] rd;
    logic [7:0] m0;
    m0 = mode_a;
    chan_a = pat;
    frame_open(1'b1);
    check("R6 oe while selected", oe_a, 1'b1);
    frame_bits(8, 16'h0, 1'b0, rd);
    frame_close();
    check("R3 R4 read pattern", rd[7:0], pat);
    check("R7 mode unchanged by read", mode_a, m0);
    check("R2 oe released", oe_a, 1'b0);
  endtask

  task automatic t_write(input logic [7:0] val, input logic [7:0] old_shreg);
    logic [15:0] rd;
    logic [7:0] m0;
    m0 = mode_a;
    frame_open(1'b0);
    frame_bits(8, {8'h0, val}, 1'b0, rd);
    check("R5 mode held mid-frame", mode_a, m0);
    frame_close();
    check("R5 mode latched on cs rise", mode_a, val);
    check("R6 cfg shift-out of old contents", rd[7:0], old_shreg);
  endtask

  task automatic t_idle_clocks(input logic [7:0] shreg);
    logic [15:0] rd;
    sel = 1'b0;
    sdi = 1'b1;
    wait_cyc(HOLD);
    for (int i = 0; i < 8; i++) begin
      sclk = 1'b1; wait_cyc(HOLD);
      check("R2 oe low while deselected", oe_a, 1'b0);
      sclk = 1'b0; wait_cyc(HOLD);
    end
    frame_open(1'b0);
    frame_bits(0, 16'h0, 1'b0, rd);
    frame_close();
    check("R2 clocks ignored while deselected", mode_a, shreg);
  endtask

  task automatic t_short(input logic [7:0] shreg);
    logic [15:0] rd;
    logic [7:0] exp;
    exp = {shreg[4:0], 3'b101};
    frame_open(1'b0);
    frame_bits(3, 16'h0005, 1'b0, rd);
    frame_close();
    check("R8 short frame latch", mode_a, exp);
  endtask

  task automatic t_chain_read();
    logic [15:0] rd;
    chan_a = 8'hC3;
    chan_b = 8'h71;
    frame_open(1'b1);
    frame_bits(16, 16'h0, 1'b1, rd);
    frame_close();
    check("R9 chain read far byte first", rd[15:8], 8'h71);
    check("R9 chain read near byte last", rd[7:0], 8'hC3);
  endtask

  task automatic t_chain_write();
    logic [15:0] rd;
    frame_open(1'b0);
    frame_bits(16, 16'h1EB4, 1'b1, rd);
    frame_close();
    check("R10 chain write far block", mode_b, 8'h1E);
    check("R10 chain write near block", mode_a, 8'hB4);
  endtask

  initial begin
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset();
    t_read(8'h96);
    t_read(8'h5A);
    t_write(8'hA5, 8'h00);
    t_write(8'h3C, 8'hA5);
    t_idle_clocks(8'h3C);
    t_short(8'h3C);
    t_chain_read();
    t_chain_write();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule